// File: doc/BRIEF.md
# Next-PC Selection Unit

This block owns the program counter of a single-cycle processor and decides which address is fetched next. Each cycle the decoder supplies a two-bit target select, a branch-sense bit, the 16-bit word offset of a conditional branch, the 26-bit field of an absolute jump, and the register operand. The register operand serves two purposes: it is the value tested against zero by conditional branches, and it is the destination address of register-indirect jumps.

The unit computes the sequential address (PC+4) and presents it as the link value for call-type instructions. From it the unit forms four candidate targets and selects one of them. On every rising clock edge the selected address is loaded into the PC register. A synchronous reset loads a parameterised reset vector instead.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `pc` is loaded with the parameter `RESET_VEC` (default 0).
- R2: `link` always equals `pc + 4`, modulo 2^32.
- R3: With `pc_sel` = 2'd0 (sequential), `next_pc` equals `pc + 4`.
- R4: With `pc_sel` = 2'd1 (conditional branch) and the branch taken, `next_pc` equals `pc + 4 + 4 * sext(br_ofs)`, where `br_ofs` is a signed 16-bit word count. This gives a reach of plus or minus 128 KB.
- R5: With `pc_sel` = 2'd1, `br_ne` = 0 takes the branch when `rs_val` is zero, and `br_ne` = 1 takes it when `rs_val` is non-zero. A branch that is not taken gives `next_pc = pc + 4`.
- R6: With `pc_sel` = 2'd2 (absolute jump), `next_pc` is formed from three fields, from high to low: bits 31..28 of `pc + 4`, then `jmp_tgt`, then two zero bits.
- R7: With `pc_sel` = 2'd3 (register-indirect), `next_pc` equals `rs_val` with bits 1..0 cleared.
- R8: `ind_misalign` is high exactly when `pc_sel` = 2'd3 and `rs_val[1:0]` is non-zero. It is low in all other cases.
- R9: Outside reset, `pc` takes the value of `next_pc` at every rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pc_sel | input | 2 | Target select: 0 sequential, 1 branch, 2 absolute, 3 indirect |
| br_ne | input | 1 | Branch sense: 0 taken on zero, 1 taken on non-zero |
| br_ofs | input | 16 | Signed branch offset in words |
| jmp_tgt | input | 26 | Absolute jump word field |
| rs_val | input | 32 | Register operand: zero-test value and indirect target |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address loaded at the next edge |
| link | output | 32 | Sequential address pc+4 |
| ind_misalign | output | 1 | Indirect target had non-zero low bits |

## Verification
In a register-indirect jump, the target computation and the misalignment detection act on the same operand in the same cycle. The bench sweeps every value of the two low bits of the operand, combined with several upper patterns. In each case it checks that `next_pc` carries the cleared bits and that the flag rises only when those bits were non-zero. The bench also puts the PC just below a 256 MB boundary and then issues an absolute jump. In that cycle the sequential increment and the jump splice interact, and the expected upper bits are taken from pc+4 rather than from pc.

// File: rtl/npc_pkg.sv
package npc_pkg;
    typedef enum logic [1:0] {
        NPC_SEQ    = 2'd0,
        NPC_BRANCH = 2'd1,
        NPC_ABS    = 2'd2,
        NPC_IND    = 2'd3
    } npc_sel_e;
endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur,
    output logic [AW-1:0] seq
);
    localparam logic [AW-1:0] STEP = AW'(4);
    always_comb seq = cur + STEP;
endmodule

// File: rtl/npc_branch.sv
module npc_branch #(
    parameter int AW    = 32,
    parameter int OFS_W = 16
) (
    input  logic [AW-1:0]    base,
    input  logic [OFS_W-1:0] ofs,
    input  logic [AW-1:0]    test_val,
    input  logic             sense_ne,
    output logic [AW-1:0]    target,
    output logic             taken
);
    localparam int EXT_W = AW - OFS_W - 2;
    logic [AW-1:0] byte_ofs;
    logic          is_zero;

    generate
        if (EXT_W > 0) begin : g_ext
            always_comb byte_ofs = {{EXT_W{ofs[OFS_W-1]}}, ofs, 2'b00};
        end else begin : g_trunc
            always_comb byte_ofs = AW'({ofs, 2'b00});
        end
    endgenerate

    always_comb begin
        is_zero = (test_val == '0);
        taken   = sense_ne ? !is_zero : is_zero;
        target  = base + byte_ofs;
    end
endmodule

// File: rtl/npc_jump.sv
module npc_jump #(
    parameter int AW    = 32,
    parameter int TGT_W = 26
) (
    input  logic [AW-TGT_W-3:0] region,
    input  logic [TGT_W-1:0]    tgt,
    output logic [AW-1:0]       target
);
    always_comb target = {region, tgt, 2'b00};
endmodule

// File: rtl/npc_indirect.sv
module npc_indirect #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] src,
    output logic [AW-1:0] target,
    output logic          low_set
);
    always_comb begin
        target  = {src[AW-1:2], 2'b00};
        low_set = (src[1:0] != 2'b00);
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int              AW        = 32,
    parameter int              OFS_W     = 16,
    parameter int              TGT_W     = 26,
    parameter logic [AW-1:0]   RESET_VEC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       pc_sel,
    input  logic             br_ne,
    input  logic [OFS_W-1:0] br_ofs,
    input  logic [TGT_W-1:0] jmp_tgt,
    input  logic [AW-1:0]    rs_val,
    output logic [AW-1:0]    pc,
    output logic [AW-1:0]    next_pc,
    output logic [AW-1:0]    link,
    output logic             ind_misalign
);
    localparam int REGION_LO = TGT_W + 2;

    typedef struct packed {
        logic [AW-1:0] pc;
    } npc_state_t;

    npc_state_t st_d, st_q;
    npc_sel_e   sel;

    logic [AW-1:0] seq_addr;
    logic [AW-1:0] br_addr;
    logic          br_taken;
    logic [AW-1:0] abs_addr;
    logic [AW-1:0] ind_addr;
    logic          ind_low;

    npc_incr #(.AW(AW)) i_incr (
        .cur (st_q.pc),
        .seq (seq_addr)
    );

    npc_branch #(.AW(AW), .OFS_W(OFS_W)) i_branch (
        .base     (seq_addr),
        .ofs      (br_ofs),
        .test_val (rs_val),
        .sense_ne (br_ne),
        .target   (br_addr),
        .taken    (br_taken)
    );

    npc_jump #(.AW(AW), .TGT_W(TGT_W)) i_jump (
        .region (seq_addr[AW-1:REGION_LO]),
        .tgt    (jmp_tgt),
        .target (abs_addr)
    );

    npc_indirect #(.AW(AW)) i_ind (
        .src     (rs_val),
        .target  (ind_addr),
        .low_set (ind_low)
    );

    always_comb begin
        sel      = npc_sel_e'(pc_sel);
        st_d     = st_q;
        unique case (sel)
            NPC_SEQ:    st_d.pc = seq_addr;
            NPC_BRANCH: st_d.pc = br_taken ? br_addr : seq_addr;
            NPC_ABS:    st_d.pc = abs_addr;
            NPC_IND:    st_d.pc = ind_addr;
            default:    st_d.pc = seq_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pc <= RESET_VEC;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc           = st_q.pc;
    assign next_pc      = st_d.pc;
    assign link         = seq_addr;
    assign ind_misalign = (sel == NPC_IND) && ind_low;
endmodule

// File: rtl/npc_checker.sv
module npc_checker #(
    parameter int            AW        = 32,
    parameter int            OFS_W     = 16,
    parameter int            TGT_W     = 26,
    parameter logic [AW-1:0] RESET_VEC = '0
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       pc_sel,
    input logic             br_ne,
    input logic [OFS_W-1:0] br_ofs,
    input logic [TGT_W-1:0] jmp_tgt,
    input logic [AW-1:0]    rs_val,
    input logic [AW-1:0]    pc,
    input logic [AW-1:0]    next_pc,
    input logic [AW-1:0]    link,
    input logic             ind_misalign
);
    a_r1_reset_vector: assert property (@(posedge clk)
        rst |=> pc == RESET_VEC);

    a_r9_register_update: assert property (@(posedge clk) disable iff (rst)
        !rst |=> pc == $past(next_pc));

    a_r3_sequential_step: assert property (@(posedge clk) disable iff (rst)
        pc_sel == 2'd0 |=> pc == $past(pc) + AW'(4));

    a_r5_not_taken: assert property (@(posedge clk) disable iff (rst)
        (pc_sel == 2'd1) && (br_ne == (rs_val == '0)) |-> next_pc == link);

    a_r6_region_bits: assert property (@(posedge clk) disable iff (rst)
        pc_sel == 2'd2 |-> next_pc[AW-1:TGT_W+2] == link[AW-1:TGT_W+2]);

    a_r7_aligned_indirect: assert property (@(posedge clk) disable iff (rst)
        pc_sel == 2'd3 |-> next_pc[1:0] == 2'b00);

    a_r8_flag_only_indirect: assert property (@(posedge clk) disable iff (rst)
        ind_misalign |-> (pc_sel == 2'd3) && (rs_val[1:0] != 2'b00));

    wire unused_ok = ^{br_ofs, jmp_tgt};
endmodule

bind npc_unit npc_checker #(
    .AW(AW), .OFS_W(OFS_W), .TGT_W(TGT_W), .RESET_VEC(RESET_VEC)
) i_npc_checker (
    .clk(clk), .rst(rst), .pc_sel(pc_sel), .br_ne(br_ne), .br_ofs(br_ofs),
    .jmp_tgt(jmp_tgt), .rs_val(rs_val), .pc(pc), .next_pc(next_pc),
    .link(link), .ind_misalign(ind_misalign)
);

// File: tb/test_npc_unit.sv
module test_npc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  pc_sel = 2'd0;
    logic        br_ne = 1'b0;
    logic [15:0] br_ofs = '0;
    logic [25:0] jmp_tgt = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] pc, next_pc, link;
    logic        ind_misalign;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] model_pc;

    always #5 clk = ~clk;

    npc_unit i_npc_unit (
        .clk(clk), .rst(rst), .pc_sel(pc_sel), .br_ne(br_ne), .br_ofs(br_ofs),
        .jmp_tgt(jmp_tgt), .rs_val(rs_val), .pc(pc), .next_pc(next_pc),
        .link(link), .ind_misalign(ind_misalign)
    );

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_next(logic [1:0] s, logic ne,
            logic [15:0] ofs, logic [25:0] tgt, logic [31:0] rs, logic [31:0] cur);
        logic [31:0] seq;
        logic        tk;
        seq = cur + 32'd4;
        case (s)
            2'd0: return seq;
            2'd1: begin
                tk = ne ? (rs != 0) : (rs == 0);
                if (tk) return seq + 32'(int'($signed(ofs)) * 4);
                return seq;
            end
            2'd2: return (seq & 32'hF000_0000) + 32'(tgt) * 32'd4;
            default: return rs - 32'(rs % 4);
        endcase
    endfunction

    // Apply one instruction: check combinational outputs, clock, check pc.
    task automatic step(logic [1:0] s, logic ne, logic [15:0] ofs,
                        logic [25:0] tgt, logic [31:0] rs, string req);
        logic [31:0] exp;
        pc_sel = s; br_ne = ne; br_ofs = ofs; jmp_tgt = tgt; rs_val = rs;
        #1;
        exp = expect_next(s, ne, ofs, tgt, rs, model_pc);
        check32(req, next_pc, exp);
        check32("R2 link", link, model_pc + 32'd4);
        check32("R8 misalign", 32'(ind_misalign),
                32'((s == 2'd3) && (rs % 4 != 0)));
        @(posedge clk); #1;
        check32("R9 update", pc, exp);
        model_pc = exp;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] ofs_list [6];
        logic [31:0] rs_list  [3];
        logic [25:0] tgt_list [4];
        ofs_list = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h1234};
        rs_list  = '{32'h0, 32'h1, 32'h8000_0000};
        tgt_list = '{26'h0, 26'h3FF_FFFF, 26'h155_5555, 26'h000_0001};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_pc = 32'h0;
        check32("R1 reset vector", pc, 32'h0);

        for (int i = 0; i < 4; i++) step(2'd0, 1'b0, 16'h0, 26'h0, 32'h0, "R3 sequential");

        // R4 / R5: branch sweep over sense, operand and offset
        for (int ne = 0; ne < 2; ne++)
            for (int r = 0; r < 3; r++)
                for (int o = 0; o < 6; o++)
                    step(2'd1, ne[0], ofs_list[o], 26'h0, rs_list[r], "R4/R5 branch");

        // R6: absolute jumps from just below a 256 MB boundary
        for (int t = 0; t < 4; t++) begin
            step(2'd3, 1'b0, 16'h0, 26'h0, 32'hAFFF_FFFC, "R7 indirect");
            step(2'd2, 1'b0, 16'h0, tgt_list[t], 32'h0, "R6 absolute");
            step(2'd2, 1'b0, 16'h0, tgt_list[t] ^ 26'h2AA_AAAA, 32'h0, "R6 absolute");
        end

        // R7 / R8: low-bit sweep with several upper patterns
        for (int hi = 0; hi < 4; hi++)
            for (int lo = 0; lo < 4; lo++)
                step(2'd3, 1'b0, 16'h0, 26'h0,
                     (32'h1357_9BDC * 32'(hi + 1)) | 32'(lo), "R7/R8 indirect");

        // Selects other than indirect keep the flag low despite odd operand
        step(2'd1, 1'b1, 16'h0010, 26'h0, 32'h3, "R8 branch odd operand");
        step(2'd0, 1'b0, 16'h0, 26'h0, 32'h3, "R8 seq odd operand");

        // Wrap at the top of the address space
        step(2'd3, 1'b0, 16'h0, 26'h0, 32'hFFFF_FFFF, "R7 top");
        step(2'd0, 1'b0, 16'h0, 26'h0, 32'h0, "R3 wrap");

        // R1: reset in mid-run overrides a pending jump
        pc_sel = 2'd2; jmp_tgt = 26'h123_4567; rst = 1'b1;
        @(posedge clk); #1;
        check32("R1 mid-run reset", pc, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        model_pc = 32'h0;
        step(2'd0, 1'b0, 16'h0, 26'h0, 32'h0, "R3 after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule